// File: doc/BRIEF.md
# Path trace identifier monitor

This block watches the trace byte of one path. One byte arrives per multiframe, marked by a valid strobe. The block gathers the bytes into trace messages using one of four selectable framing modes. It declares a message stable once the same message has arrived three times in a row, and it keeps that message in a capture buffer that can be read at any time. It also raises a trace-mismatch flag when the received messages persistently differ from a reference.

In the framed modes and the single-byte mode, the reference is an external expected-trace memory. The block drives the read address of that memory and takes the data back in the same cycle. In the cyclic mode there is no external reference. Once a message has been accepted, each later repeat is compared with that accepted message. The mode and the cyclic length are configuration. They are set while reset is asserted and held afterwards.

Top module: `trace_id_monitor`

## Requirements
- R1: During and after reset, with no bytes received, `mismatch` and `stable` are 0 and every capture buffer entry reads 0.
- R2: In single-byte mode (`mode` = 3), every valid byte is one complete message, and it is compared with expected entry 0.
- R3: `mismatch` rises after the third consecutive completed message that differs from its reference. It does not rise after only two.
- R4: A raised `mismatch` falls after the third consecutive completed message that equals its reference. It does not fall after only two.
- R5: `stable` is 1 after a completed message equals each of the two completed messages before it, with no dropped message between them. At that point the capture buffer holds this message. A completed message that differs from the previous one, or a dropped message, clears `stable`.
- R6: In SONET mode (`mode` = 1), a message is 64 bytes long, and bytes 62 and 63 are 0x0D and 0x0A. A 0x0D,0x0A pair that ends anywhere else, or 64 bytes without that ending, drops the bytes collected so far, and alignment restarts after them.
- R7: In SDH mode (`mode` = 2), a message is 16 bytes long and starts at a byte whose bit 7 is 1. The low 7 bits of that first byte carry a CRC-7. The CRC uses polynomial x^7+x^3+1 with a zero start value. It is computed most significant bit first over all 16 bytes, with the low 7 bits of byte 0 taken as zero. A message with a wrong CRC is dropped, and a byte with bit 7 set restarts the message.
- R8: In SDH mode, bytes with bit 7 clear that arrive between messages are ignored and do not break persistence.
- R9: In cyclic mode (`mode` = 0), a message is `cyc_last`+1 bytes long with no alignment marker. Messages are compared with the accepted capture buffer, and mismatch counting starts only after a first acceptance.
- R10: While `in_valid` is 0, `in_byte` has no effect on any output.
- R11: `exp_addr` gives the position, within its message, of the byte currently presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 cyclic, 1 SONET, 2 SDH, 3 single byte |
| cyc_last | input | 6 | Cyclic message length minus one |
| in_valid | input | 1 | Trace byte strobe |
| in_byte | input | 8 | Received trace byte |
| exp_addr | output | 6 | Expected-trace memory read address |
| exp_byte | input | 8 | Expected-trace memory read data, same cycle |
| rd_addr | input | 6 | Capture buffer read address |
| rd_byte | output | 8 | Capture buffer read data, combinational |
| mismatch | output | 1 | Trace mismatch flag |
| stable | output | 1 | Trace stable flag |

## Verification
The address `exp_addr` follows the presented byte with no delay, so the bench checks it while the byte is still held, before the clock edge that takes it. `mismatch` and `stable` are registered and change on the edge that takes a message's last byte. The bench therefore reads them at the falling edge that follows that last byte, and never earlier in the message. `rd_byte` is a combinational read of the capture buffer, which was loaded on that same edge. The bench sets `rd_addr` and reads the data a moment later.

// File: rtl/trace_id_monitor.sv
module trace_id_monitor #(
  parameter int MSG_MAX = 64,
  parameter int SDH_LEN = 16,
  localparam int AW = $clog2(MSG_MAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] cyc_last,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  output logic [AW-1:0] exp_addr,
  input  logic [7:0]    exp_byte,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_byte,
  output logic          mismatch,
  output logic          stable
);
  localparam logic [1:0] M_CYC = 2'd0, M_SONET = 2'd1, M_SDH = 2'd2, M_BYTE = 2'd3;

  logic [7:0]    last_q [MSG_MAX];
  logic [7:0]    acc_q  [MSG_MAX];
  logic [AW-1:0] pos_q, pos_n, idx;
  logic          sync_q, cr_q, dl_q, dr_q, acc_ok_q, tim_q, stb_q;
  logic [1:0]    per_q, per_n, bad_q, good_q;
  logic [6:0]    crc_q, crc_n;
  logic          take, done, drop, first, dl_n, dr_n, crlf;

  function automatic logic [6:0] crc7(input logic [6:0] c, input logic [7:0] b);
    logic [6:0] r;
    r = c;
    for (int k = 7; k >= 0; k--) begin
      logic fb;
      fb = r[6] ^ b[k];
      r  = {r[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return r;
  endfunction

  always_comb begin
    case (mode)
      M_SDH:   idx = in_byte[7] ? '0 : pos_q;
      M_BYTE:  idx = '0;
      default: idx = pos_q;
    endcase
  end

  assign exp_addr = idx;
  assign rd_byte  = acc_q[rd_addr];
  assign mismatch = tim_q;
  assign stable   = stb_q;

  assign first = (idx == '0);
  assign dl_n  = (!first & dl_q) | (last_q[idx] != in_byte);
  assign dr_n  = (!first & dr_q) | (((mode == M_CYC) ? acc_q[idx] : exp_byte) != in_byte);
  assign crc_n = crc7(first ? 7'd0 : crc_q, first ? {in_byte[7], 7'd0} : in_byte);
  assign crlf  = cr_q & (in_byte == 8'h0A);
  assign per_n = (per_q != 2'd0 && !dl_n) ? ((per_q == 2'd3) ? 2'd3 : per_q + 2'd1) : 2'd1;

  always_comb begin
    take  = 1'b1;
    done  = 1'b0;
    drop  = 1'b0;
    pos_n = pos_q + 1'b1;
    case (mode)
      M_CYC: begin
        done = (pos_q == cyc_last);
        if (done) pos_n = '0;
      end
      M_SONET: begin
        done = crlf & (pos_q == AW'(MSG_MAX - 1));
        drop = crlf ^ (pos_q == AW'(MSG_MAX - 1));
        if (crlf || pos_q == AW'(MSG_MAX - 1)) pos_n = '0;
      end
      M_SDH: begin
        if (in_byte[7]) begin
          drop  = sync_q;
          pos_n = AW'(1);
        end else if (!sync_q) begin
          take  = 1'b0;
          pos_n = pos_q;
        end else if (pos_q == AW'(SDH_LEN - 1)) begin
          done  = (crc_n == last_q[0][6:0]);
          drop  = !done;
          pos_n = '0;
        end
      end
      default: begin
        done  = 1'b1;
        pos_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MSG_MAX; i++) begin
        last_q[i] <= '0;
        acc_q[i]  <= '0;
      end
      pos_q <= '0; crc_q <= '0; per_q <= '0; bad_q <= '0; good_q <= '0;
      sync_q <= 1'b0; cr_q <= 1'b0; dl_q <= 1'b0; dr_q <= 1'b0;
      acc_ok_q <= 1'b0; tim_q <= 1'b0; stb_q <= 1'b0;
    end else if (in_valid) begin
      cr_q <= (in_byte == 8'h0D);
      if (take) begin
        last_q[idx] <= in_byte;
        pos_q <= pos_n;
        crc_q <= crc_n;
        dl_q  <= dl_n;
        dr_q  <= dr_n;
        if (mode == M_SDH) sync_q <= in_byte[7] | (sync_q & (pos_q != AW'(SDH_LEN - 1)));
        if (drop) begin
          per_q <= '0;
          stb_q <= 1'b0;
        end else if (done) begin
          per_q <= per_n;
          stb_q <= (per_n == 2'd3);
          if (per_n == 2'd3) begin
            for (int i = 0; i < MSG_MAX; i++)
              acc_q[i] <= (AW'(i) == idx) ? in_byte : last_q[i];
            acc_ok_q <= 1'b1;
          end
          if (mode != M_CYC || acc_ok_q) begin
            if (dr_n) begin
              good_q <= '0;
              if (bad_q != 2'd3) bad_q <= bad_q + 2'd1;
              if (bad_q >= 2'd2) tim_q <= 1'b1;
            end else begin
              bad_q <= '0;
              if (good_q != 2'd3) good_q <= good_q + 2'd1;
              if (good_q >= 2'd2) tim_q <= 1'b0;
            end
          end
        end
      end
    end
  end

  p_tim_on_rx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mismatch) |-> $past(in_valid));
  p_tim_off_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mismatch) |-> $past(in_valid));
  p_stable_on_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stable) |-> $past(in_valid));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(mismatch) && $stable(stable));
  p_single_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_BYTE |-> exp_addr == '0);
  p_sdh_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_SDH && in_byte[7] |-> exp_addr == '0);
  p_cyc_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_CYC |-> exp_addr <= cyc_last);
endmodule

// File: tb/tb_trace_id_monitor.sv
`timescale 1ns/1ps
module tb_trace_id_monitor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd3;
  logic [5:0] cyc_last = 6'd0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic [5:0] exp_addr, rd_addr = 6'd0;
  logic [7:0] exp_byte, rd_byte;
  logic       mismatch, stable;
  logic [7:0] exp_mem [64];
  logic [7:0] tx [64];
  logic [7:0] son [64];
  logic [7:0] sdh [16];
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;
  assign exp_byte = exp_mem[exp_addr];

  trace_id_monitor dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cyc_last(cyc_last),
    .in_valid(in_valid), .in_byte(in_byte), .exp_addr(exp_addr),
    .exp_byte(exp_byte), .rd_addr(rd_addr), .rd_byte(rd_byte),
    .mismatch(mismatch), .stable(stable));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m, input logic [5:0] cl);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; mode = m; cyc_last = cl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] b, input int probe);
    @(negedge clk);
    in_valid = 1'b1; in_byte = b;
    #0.1;
    if (probe >= 0) chk("R11 exp_addr", exp_addr, probe);
    @(posedge clk);
  endtask

  task automatic idle;
    @(negedge clk);
    in_valid = 1'b0;
    #0.1;
  endtask

  task automatic send_tx(input int n, input int probe);
    for (int i = 0; i < n; i++) send_byte(tx[i], (i == probe) ? i : -1);
    idle();
  endtask

  task automatic flags(input string req, input logic m, input logic s);
    chk({req, " mismatch"}, mismatch, m);
    chk({req, " stable"}, stable, s);
  endtask

  task automatic rd(input string req, input int a, input int exp);
    rd_addr = 6'(a);
    #0.1;
    chk(req, rd_byte, exp);
  endtask

  function automatic logic [6:0] bench_crc();
    logic [6:0] c = 7'd0;
    for (int i = 0; i < 16; i++)
      for (int k = 7; k >= 0; k--) begin
        logic bitv, fb;
        bitv = (i == 0 && k < 7) ? 1'b0 : sdh[i][k];
        fb = c[6] ^ bitv;
        c = {c[5:0], 1'b0};
        if (fb) c = c ^ 7'h09;
      end
    return c;
  endfunction

  task automatic t_reset;
    do_reset(2'd3, 6'd0);
    idle();
    flags("R1", 1'b0, 1'b0);
    rd("R1 capture", 0, 0);
    rd("R1 capture", 63, 0);
  endtask

  task automatic t_single;
    do_reset(2'd3, 6'd0);
    exp_mem[0] = 8'h41;
    for (int i = 0; i < 3; i++) send_byte(8'h41, 0);
    idle(); flags("R2 match", 1'b0, 1'b1);
    rd("R5 capture", 0, 8'h41);
    send_byte(8'h55, -1); idle(); flags("R5 change", 1'b0, 1'b0);
    send_byte(8'h55, -1); idle(); chk("R3 two bad", mismatch, 0);
    send_byte(8'h55, -1); idle(); flags("R3 three bad", 1'b1, 1'b1);
    rd("R5 capture new", 0, 8'h55);
    in_byte = 8'h41;
    repeat (6) begin @(negedge clk); in_byte = in_byte + 8'h11; end
    #0.1; flags("R10 idle", 1'b1, 1'b1);
    rd("R10 capture", 0, 8'h55);
    send_byte(8'h41, -1); send_byte(8'h41, -1); idle();
    chk("R4 two good", mismatch, 1);
    send_byte(8'h41, -1); idle(); flags("R4 three good", 1'b0, 1'b1);
  endtask

  task automatic t_sonet;
    do_reset(2'd1, 6'd0);
    for (int i = 0; i < 62; i++) son[i] = 8'(8'h20 + i);
    son[62] = 8'h0D; son[63] = 8'h0A;
    for (int i = 0; i < 64; i++) exp_mem[i] = son[i];
    for (int i = 0; i < 5; i++) tx[i] = 8'h30;
    for (int i = 5; i < 64; i++) tx[i] = son[i - 5];
    send_tx(64, -1);
    for (int i = 59; i < 64; i++) send_byte(son[i], -1);
    for (int i = 0; i < 64; i++) tx[i] = son[i];
    send_tx(64, -1); send_tx(64, 20);
    flags("R6 two after realign", 1'b0, 1'b0);
    send_tx(64, -1); flags("R6 aligned", 1'b0, 1'b1);
    rd("R6 capture crlf", 62, 8'h0D);
    rd("R6 capture body", 5, 8'h25);
    tx[10] = 8'h7E;
    send_tx(64, -1); flags("R6 altered one", 1'b0, 1'b0);
    send_tx(64, -1); send_tx(64, -1);
    flags("R3 sonet", 1'b1, 1'b1);
    rd("R5 sonet capture", 10, 8'h7E);
    for (int i = 0; i < 8; i++) send_byte(8'h30, -1);
    send_byte(8'h0D, -1); send_byte(8'h0A, -1); idle();
    chk("R6 short drop stable", stable, 0);
    send_tx(64, -1); flags("R6 after drop", 1'b1, 1'b0);
  endtask

  task automatic t_sdh;
    do_reset(2'd2, 6'd0);
    sdh[0] = 8'h80;
    for (int i = 1; i < 16; i++) sdh[i] = 8'(8'h40 + i);
    sdh[0] = {1'b1, bench_crc()};
    for (int i = 0; i < 16; i++) begin exp_mem[i] = sdh[i]; tx[i] = sdh[i]; end
    for (int i = 0; i < 3; i++) send_byte(8'h11, -1);
    send_tx(16, -1); send_tx(16, 7);
    flags("R7 two", 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) send_byte(8'h11, -1);
    send_tx(16, 0);
    flags("R8 gap ignored", 1'b0, 1'b1);
    rd("R7 capture head", 0, sdh[0]);
    rd("R7 capture tail", 15, sdh[15]);
    tx[0] = sdh[0] ^ 8'h01;
    send_tx(16, -1); flags("R7 bad crc", 1'b0, 1'b0);
    tx[0] = sdh[0];
    send_tx(16, -1); chk("R7 after drop", stable, 0);
    for (int i = 0; i < 5; i++) send_byte(tx[i], -1);
    send_tx(16, -1); chk("R7 restart", stable, 0);
    send_tx(16, -1); send_tx(16, -1);
    flags("R7 recovered", 1'b0, 1'b1);
  endtask

  task automatic t_cyclic;
    logic [7:0] c4 [4];
    logic [7:0] d4 [4];
    do_reset(2'd0, 6'd3);
    c4 = '{8'h10, 8'h20, 8'h30, 8'h40};
    d4 = '{8'h10, 8'h21, 8'h30, 8'h40};
    for (int i = 0; i < 64; i++) exp_mem[i] = 8'hEE;
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 4; i++) send_byte((r % 2 == 0) ? c4[i] : d4[i], -1);
      idle();
    end
    flags("R9 no acceptance", 1'b0, 1'b0);
    do_reset(2'd0, 6'd3);
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 4; i++) send_byte(c4[i], (r == 1) ? i : -1);
      idle();
    end
    flags("R9 accepted", 1'b0, 1'b1);
    rd("R9 capture", 2, 8'h30);
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < 4; i++) send_byte(d4[i], -1);
      idle();
    end
    flags("R9 two changed", 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) send_byte(d4[i], -1);
    idle(); flags("R9 three changed", 1'b1, 1'b1);
    rd("R9 capture new", 1, 8'h21);
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 4; i++) send_byte(d4[i], -1);
      idle();
    end
    flags("R4 cyclic clear", 1'b0, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) exp_mem[i] = 8'h00;
    t_reset();
    t_single();
    t_sonet();
    t_sdh();
    t_cyclic();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule